// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block is a small multi-ported register file of eight general-purpose words, meant to sit beside an execution datapath. Two read ports and one write port work in parallel, each with its own 4-bit register selector, so one cycle can fetch two operands and store one result. The selector is the address: codes 0 to 7 name real words, and any code from 8 to 15 means "no register".

Reads are combinational. A read output follows its selector and the stored contents with only gate delay and never waits for a clock. Writes are the only clocked action: the addressed word takes the write data at the rising clock edge and holds it until a later edge. A "no register" code on the write port drops the write. The same code on a read port drives zero. A synchronous active-high reset clears every word.

Top module: `regfile_2r1w`

## Requirements
- R1: When `rst` is high at a rising clock edge, every word becomes zero and any write in that cycle is dropped.
- R2: When `wr_sel` is 0 to 7 at a rising edge and `rst` is low, the word with that index takes `wr_data`.
- R3: When `wr_sel` is 8 to 15 at an edge, no word changes.
- R4: `rd_a_data` shows the word chosen by `rd_a_sel` combinationally, and follows a change of `rd_a_sel` between clock edges.
- R5: `rd_b_data` shows the word chosen by `rd_b_sel` combinationally, independent of port A.
- R6: A read selector of 8 to 15 gives all-zero read data.
- R7: A read of the word being written in the same cycle gives the old value before the edge and the new value after it.
- R8: A write changes only the word it addresses. Every other word keeps its value.
- R9: When both read selectors name the same word, both outputs carry the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all words |
| rd_a_sel | input | 4 | Read port A selector (8 to 15 = none) |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_sel | input | 4 | Read port B selector (8 to 15 = none) |
| rd_b_data | output | DATA_W | Read port B data |
| wr_sel | input | 4 | Write selector (8 to 15 = none) |
| wr_data | input | DATA_W | Write data |

## Verification
A read and a write can address the same word in one cycle. That is the case where combinational reading meets clocked storage. The bench holds a read selector on the word that the write port is loading. It samples the read output once in the low phase before the edge, where it expects the shadow array's old value, and once just after the edge, where it expects the new value. The checker also watches this collision each cycle by comparing read data against the write data from the cycle before.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int RF_DATA_W   = 32;
    localparam int RF_NUM_REGS = 8;
    localparam int RF_SEL_W    = 4;

    // Decoded selector: whether it names a real word, and that word's index.
    typedef struct packed {
        logic                hit;
        logic [RF_SEL_W-1:0] idx;
    } rf_sel_t;

    function automatic rf_sel_t rf_classify(input logic [RF_SEL_W-1:0] sel,
                                            input logic [RF_SEL_W-1:0] first_none);
        rf_sel_t r;
        r.hit = (sel < first_none);
        r.idx = sel;
        return r;
    endfunction

endpackage

// File: rtl/rf_sel_decode.sv
module rf_sel_decode
    import rf_pkg::*;
#(
    parameter int NUM_REGS = RF_NUM_REGS
) (
    input  logic [RF_SEL_W-1:0] sel,
    output logic                hit,
    output logic [NUM_REGS-1:0] onehot
);
    localparam logic [RF_SEL_W-1:0] FIRST_NONE = RF_SEL_W'(NUM_REGS);

    rf_sel_t dec;

    always_comb dec = rf_classify(sel, FIRST_NONE);

    assign hit = dec.hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_line
        assign onehot[i] = dec.hit && (dec.idx == RF_SEL_W'(i));
    end

endmodule

// File: rtl/rf_word_array.sv
module rf_word_array
    import rf_pkg::*;
#(
    parameter int DATA_W   = RF_DATA_W,
    parameter int NUM_REGS = RF_NUM_REGS
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_REGS-1:0]               we,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   words
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[i] <= '0;
            end else if (we[i]) begin
                words[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
#(
    parameter int DATA_W   = RF_DATA_W,
    parameter int NUM_REGS = RF_NUM_REGS
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0]   words,
    input  logic [RF_SEL_W-1:0]               sel,
    output logic [DATA_W-1:0]                 data
);
    logic                hit;
    logic [NUM_REGS-1:0] pick;

    rf_sel_decode #(.NUM_REGS(NUM_REGS)) i_dec (
        .sel    (sel),
        .hit    (hit),
        .onehot (pick)
    );

    // AND-OR select: an empty one-hot vector yields zero.
    always_comb begin
        data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (pick[i]) data = data | words[i];
        end
    end

    logic unused_hit;
    assign unused_hit = hit;

endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
    import rf_pkg::*;
#(
    parameter int DATA_W   = RF_DATA_W,
    parameter int NUM_REGS = RF_NUM_REGS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [RF_SEL_W-1:0] rd_a_sel,
    output logic [DATA_W-1:0]   rd_a_data,
    input  logic [RF_SEL_W-1:0] rd_b_sel,
    output logic [DATA_W-1:0]   rd_b_data,
    input  logic [RF_SEL_W-1:0] wr_sel,
    input  logic [DATA_W-1:0]   wr_data
);
    logic                            wr_hit;
    logic [NUM_REGS-1:0]             wr_onehot;
    logic [NUM_REGS-1:0][DATA_W-1:0] words;

    rf_sel_decode #(.NUM_REGS(NUM_REGS)) i_wr_dec (
        .sel    (wr_sel),
        .hit    (wr_hit),
        .onehot (wr_onehot)
    );

    rf_word_array #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) i_array (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_onehot),
        .wdata (wr_data),
        .words (words)
    );

    rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) i_rd_a (
        .words (words),
        .sel   (rd_a_sel),
        .data  (rd_a_data)
    );

    rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) i_rd_b (
        .words (words),
        .sel   (rd_b_sel),
        .data  (rd_b_data)
    );

    logic unused_wr_hit;
    assign unused_wr_hit = wr_hit;

endmodule

// File: rtl/rf_chk.sv
module rf_chk
    import rf_pkg::*;
#(
    parameter int DATA_W   = RF_DATA_W,
    parameter int NUM_REGS = RF_NUM_REGS
) (
    input logic                clk,
    input logic                rst,
    input logic [RF_SEL_W-1:0] rd_a_sel,
    input logic [DATA_W-1:0]   rd_a_data,
    input logic [RF_SEL_W-1:0] rd_b_sel,
    input logic [DATA_W-1:0]   rd_b_data,
    input logic [RF_SEL_W-1:0] wr_sel,
    input logic [DATA_W-1:0]   wr_data
);
    localparam logic [RF_SEL_W-1:0] FIRST_NONE = RF_SEL_W'(NUM_REGS);

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_sel) < FIRST_NONE && rd_a_sel == $past(wr_sel))
        |-> rd_a_data == $past(wr_data));

    // R8
    others_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rd_a_sel < FIRST_NONE && $stable(rd_a_sel)
         && $past(wr_sel) != rd_a_sel) |-> $stable(rd_a_data));

    // R6
    none_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_b_sel >= FIRST_NONE) |-> rd_b_data == '0);

    // R9
    ports_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_sel == rd_b_sel) |-> rd_a_data == rd_b_data);

endmodule

bind regfile_2r1w rf_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) i_rf_chk (.*);

// File: tb/test_regfile_2r1w.sv
`timescale 1ns/1ps
module test_regfile_2r1w;
    localparam int DW = 32;
    localparam int NR = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    rd_a_sel = 4'd8, rd_b_sel = 4'd8, wr_sel = 4'd8;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_a_data, rd_b_data;

    logic [DW-1:0] shadow [NR];
    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    regfile_2r1w #(.DATA_W(DW), .NUM_REGS(NR)) i_regfile_2r1w (
        .clk(clk), .rst(rst),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_sel(wr_sel), .wr_data(wr_data)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] sel, input logic [DW-1:0] d);
        @(negedge clk);
        wr_sel = sel; wr_data = d;
        @(posedge clk);
        if (sel < 4'(NR)) shadow[sel[2:0]] = d;
        #1;
        wr_sel = 4'd8;
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < NR; i++) begin
            @(negedge clk);
            rd_a_sel = 4'(i); rd_b_sel = 4'(NR - 1 - i);
            #1;
            check(req, rd_a_data, shadow[i]);
            check(req, rd_b_data, shadow[NR - 1 - i]);
        end
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1; wr_sel = 4'd2; wr_data = 32'hFFFF_0000;
        @(posedge clk); #1; rst = 1'b0; wr_sel = 4'd8;
        for (int i = 0; i < NR; i++) shadow[i] = '0;
        read_all("R1");
    endtask

    task automatic t_write_all;
        for (int i = 0; i < NR; i++) do_write(4'(i), 32'hA500_0000 + i * 32'h0101_0101);
        read_all("R2/R4/R5");
    endtask

    task automatic t_none_write;
        do_write(4'd8, 32'hDEAD_BEEF);
        do_write(4'd15, 32'h1234_5678);
        do_write(4'd11, 32'h0BAD_F00D);
        read_all("R3");
    endtask

    task automatic t_none_read;
        logic [3:0] codes [3] = '{4'd8, 4'd12, 4'd15};
        foreach (codes[k]) begin
            @(negedge clk);
            rd_a_sel = codes[k]; rd_b_sel = codes[k];
            #1;
            check("R6", rd_a_data, '0);
            check("R6", rd_b_data, '0);
        end
    endtask

    task automatic t_comb_read;
        @(posedge clk); #0.3;
        for (int i = 0; i < 4; i++) begin
            rd_a_sel = 4'(i); rd_b_sel = 4'(i + 4);
            #0.4;
            check("R4", rd_a_data, shadow[i]);
            check("R5", rd_b_data, shadow[i + 4]);
        end
    endtask

    task automatic t_collide;
        @(negedge clk);
        rd_a_sel = 4'd3; rd_b_sel = 4'd4;
        wr_sel = 4'd3; wr_data = 32'hC0FF_EE03;
        #1;
        check("R7 before edge", rd_a_data, shadow[3]);
        @(posedge clk); #1;
        shadow[3] = 32'hC0FF_EE03;
        wr_sel = 4'd8;
        check("R7 after edge", rd_a_data, shadow[3]);
        check("R8", rd_b_data, shadow[4]);
        read_all("R8");
    endtask

    task automatic t_same_word;
        do_write(4'd7, 32'h7777_0007);
        do_write(4'd0, 32'h0000_F00F);
        foreach (shadow[i]) begin
            @(negedge clk);
            rd_a_sel = 4'(i); rd_b_sel = 4'(i);
            #1;
            check("R9", rd_a_data, shadow[i]);
            check("R9", rd_b_data, rd_a_data);
        end
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_write_all();
        t_none_write();
        t_none_read();
        t_comb_read();
        t_collide();
        t_same_word();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule